// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block arbitrates four interrupt request sources for a small 8-bit CPU: two active-low external pins and two timer overflow events. Each external pin is captured either as a level (the request follows the sampled pin) or as a falling transition (a flag is latched and held until serviced). Software controls the block through two registers written over a simple write port: an enable register with one bit per source plus a global enable bit, and a priority register with one bit per source.

At every instruction boundary signalled by the CPU the controller picks one pending, enabled request. High-priority requests win over low ones. Within a level a fixed polling order decides. It then emits a one-cycle vector strobe with the service address and marks that priority level as in service. A return-from-interrupt at the end of an instruction releases the highest level in service. Stack pushes and the call itself belong to the CPU.

Top module: `pic2_top`

## Requirements
- R1: After reset no level is in service, `vec_stb` is 0, all request flags read 0, and the enable and priority registers are zero, so no vector is issued until software enables a source.
- R2: Source index 0 is external 0, 1 is timer 0, 2 is external 1, 3 is timer 1. `req_flag[i]` shows source i, and the vector of source i is 0x0003 + 8*i (0x0003, 0x000B, 0x0013, 0x001B).
- R3: A write with `cfg_sel`=0 loads the enable register: bit i enables source i and bit 7 is the global enable. With bit 7 clear no vector is issued whatever the other bits hold.
- R4: A write with `cfg_sel`=1 loads the priority register: bit i set makes source i high priority, clear makes it low.
- R5: Among pending, enabled requests of the chosen level, the lowest source index wins. Any high-priority request is chosen before any low one.
- R6: A high-priority request may be vectored while only the low level is in service. Nothing is vectored while the high level is in service, and a low request is not vectored while the low level is in service.
- R7: With `edge_mode[k]`=1, external pin k is sampled on cycles where `mc_tick` is 1. Its flag sets when a sample of 1 is followed by a sample of 0, and clears when that source is vectored. A new fall in the same cycle wins over the clear. With `edge_mode[k]`=0 this latch is held clear.
- R8: With `edge_mode[k]`=0 the flag of external k is the inverse of the last tick sample of the pin. Vectoring does not clear it, so a pin still low requests again after return.
- R9: A pulse on `tmr_ovf[j]` sets the timer j flag. The flag clears when timer j is vectored, and a new pulse in the same cycle wins over the clear.
- R10: A vector is decided only in a cycle with `insn_last`=1, `insn_reti`=0 and `cfg_wr`=0. A blocked request is not remembered: if its flag has dropped by the next allowed cycle, no vector follows.
- R11: A cycle with `insn_last`=1 and `insn_reti`=1 releases the high level if it is in service, otherwise the low level.
- R12: `vec_stb` is high for one cycle in the cycle after the decision, together with `vec_addr`, the in-service update and the flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe, pin sampling enable |
| ext_n | input | 2 | Active-low external request pins |
| edge_mode | input | 2 | Per pin: 1 falling transition, 0 level |
| tmr_ovf | input | 2 | Timer overflow pulses |
| cfg_wr | input | 1 | Register write strobe (also a blocking condition) |
| cfg_sel | input | 1 | 0 enable register, 1 priority register |
| cfg_wdata | input | 8 | Write data |
| insn_last | input | 1 | Last cycle of the current instruction |
| insn_reti | input | 1 | Current instruction is a return from interrupt |
| vec_stb | output | 1 | Vector taken strobe |
| vec_addr | output | 16 | Service routine address |
| svc_hi | output | 1 | High level in service |
| svc_lo | output | 1 | Low level in service |
| req_flag | output | 4 | Request flags by source index |

## Verification
The two colliding functions are flag capture and vectoring. A falling edge or timer pulse can land in the cycle where the same source is vectored, and the set must win over the hardware clear. The random phase raises overflow pulses and tick-sampled pin falls while `insn_last` is frequently high, so the set and the clear coincide many times. A cycle-accurate bench model predicts each flag after every edge and compares it with `req_flag`. Directed sequences add preemption, release order and blocking by a return or a register write.

// File: rtl/pic2_pkg.sv
package pic2_pkg;
  localparam int NSRC      = 4;
  localparam int NEXT      = NSRC / 2;
  localparam int IDX_W     = $clog2(NSRC);
  localparam int VEC_W     = 16;
  localparam int VEC_BASE  = 3;
  localparam int VEC_STEP  = 8;
  localparam int CFG_W     = 8;
  localparam int GIE_BIT   = CFG_W - 1;

  typedef struct packed {
    logic             valid;
    logic             hi;
    logic [IDX_W-1:0] idx;
  } pick_t;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction

  // lowest set index wins
  function automatic logic [IDX_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/pic2_ext_capture.sv
module pic2_ext_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  input  logic edge_md,
  input  logic clr,
  output logic flag
);
  logic smp_q;
  logic ef_q;
  logic fall;

  assign fall = tick & smp_q & ~pin_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q <= 1'b1;
      ef_q  <= 1'b0;
    end else begin
      if (tick) smp_q <= pin_n;
      if (!edge_md)  ef_q <= 1'b0;
      else if (fall) ef_q <= 1'b1;
      else if (clr)  ef_q <= 1'b0;
    end
  end

  assign flag = edge_md ? ef_q : ~smp_q;

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_md && clr && !fall) |=> !ef_q); // R7
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_md && fall) |=> ef_q); // R7
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(smp_q)); // R8
endmodule

// File: rtl/pic2_select.sv
module pic2_select
  import pic2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  flags,
  input  logic [CFG_W-1:0] en,
  input  logic [NSRC-1:0]  pri,
  input  logic             svc_hi,
  input  logic             svc_lo,
  input  logic             last,
  input  logic             reti,
  input  logic             wr,
  output logic             take,
  output pick_t            pick
);
  logic [NSRC-1:0] act, hi_req, lo_req;
  logic            can_hi, can_lo, open;

  assign act    = flags & en[NSRC-1:0] & {NSRC{en[GIE_BIT]}};
  assign hi_req = act & pri;
  assign lo_req = act & ~pri;
  assign can_hi = (|hi_req) & ~svc_hi;
  assign can_lo = (|lo_req) & ~svc_hi & ~svc_lo;
  assign open   = last & ~reti & ~wr;

  always_comb begin
    pick = '0;
    if (can_hi) begin
      pick.valid = 1'b1;
      pick.hi    = 1'b1;
      pick.idx   = first_set(hi_req);
    end else if (can_lo) begin
      pick.valid = 1'b1;
      pick.hi    = 1'b0;
      pick.idx   = first_set(lo_req);
    end
  end

  assign take = open & pick.valid;

  AST_HI_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi |-> !take); // R6
  AST_LO_ONLY_BY_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (take && svc_lo) |-> pick.hi); // R6
  AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> flags[pick.idx]); // R5
endmodule

// File: rtl/pic2_svc_track.sv
module pic2_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic release_lvl,
  output logic svc_hi,
  output logic svc_lo
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else if (take) begin
      if (take_hi) svc_hi <= 1'b1;
      else         svc_lo <= 1'b1;
    end else if (release_lvl) begin
      if (svc_hi) svc_hi <= 1'b0;
      else        svc_lo <= 1'b0;
    end
  end

  AST_SVC_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_hi && !release_lvl) |=> svc_hi); // R11
  AST_RELEASE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (release_lvl && svc_hi && svc_lo && !take) |=> (!svc_hi && svc_lo)); // R11
endmodule

// File: rtl/pic2_top.sv
module pic2_top
  import pic2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic [NEXT-1:0]   ext_n,
  input  logic [NEXT-1:0]   edge_mode,
  input  logic [NEXT-1:0]   tmr_ovf,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              insn_last,
  input  logic              insn_reti,
  output logic              vec_stb,
  output logic [VEC_W-1:0]  vec_addr,
  output logic              svc_hi,
  output logic              svc_lo,
  output logic [NSRC-1:0]   req_flag
);
  logic [CFG_W-1:0] en_q;
  logic [CFG_W-1:0] pri_q;
  logic [NSRC-1:0]  clr_src;
  logic             take;
  pick_t            pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_sel) pri_q <= cfg_wdata;
      else         en_q  <= cfg_wdata;
    end
  end

  // even index: external pin, odd index: timer
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign clr_src[i] = take & (pick.idx == IDX_W'(i));
    if (i % 2 == 0) begin : g_ext
      pic2_ext_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (mc_tick),
        .pin_n  (ext_n[i/2]),
        .edge_md(edge_mode[i/2]),
        .clr    (clr_src[i]),
        .flag   (req_flag[i])
      );
    end else begin : g_tmr
      logic tf_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              tf_q <= 1'b0;
        else if (tmr_ovf[i/2])   tf_q <= 1'b1;
        else if (clr_src[i])     tf_q <= 1'b0;
      end
      assign req_flag[i] = tf_q;
    end
  end

  pic2_select u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (req_flag),
    .en    (en_q),
    .pri   (pri_q[NSRC-1:0]),
    .svc_hi(svc_hi),
    .svc_lo(svc_lo),
    .last  (insn_last),
    .reti  (insn_reti),
    .wr    (cfg_wr),
    .take  (take),
    .pick  (pick)
  );

  pic2_svc_track u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_hi    (pick.hi),
    .release_lvl(insn_last & insn_reti),
    .svc_hi     (svc_hi),
    .svc_lo     (svc_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_stb  <= 1'b0;
      vec_addr <= '0;
    end else begin
      vec_stb <= take;
      if (take) vec_addr <= vec_of(pick.idx);
    end
  end

  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> ($past(insn_last) && !$past(insn_reti) && !$past(cfg_wr))); // R10
  AST_STB_MARKS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> (svc_hi || svc_lo)); // R12
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[GIE_BIT] |=> !vec_stb); // R3
  AST_TMR0_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_stb && vec_addr == vec_of(IDX_W'(1)) && !$past(tmr_ovf[0])) |-> !req_flag[1]); // R9
endmodule

// File: tb/test_pic2_top.sv
module test_pic2_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mc_tick;
  logic [1:0]  ext_n, edge_mode, tmr_ovf;
  logic        cfg_wr, cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        insn_last, insn_reti;
  logic        vec_stb;
  logic [15:0] vec_addr;
  logic        svc_hi, svc_lo;
  logic [3:0]  req_flag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pic2_top i_pic2_top (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ext_n(ext_n),
    .edge_mode(edge_mode), .tmr_ovf(tmr_ovf), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .insn_last(insn_last),
    .insn_reti(insn_reti), .vec_stb(vec_stb), .vec_addr(vec_addr),
    .svc_hi(svc_hi), .svc_lo(svc_lo), .req_flag(req_flag)
  );

  // reference state
  logic [1:0] m_smp, m_ef, m_tf;
  logic [7:0] m_en, m_pri;
  logic       m_hi, m_lo, m_stb;
  logic [15:0] m_addr;

  function automatic logic [3:0] m_flags();
    logic [3:0] f;
    f[0] = edge_mode[0] ? m_ef[0] : !m_smp[0];
    f[2] = edge_mode[1] ? m_ef[1] : !m_smp[1];
    f[1] = m_tf[0];
    f[3] = m_tf[1];
    return f;
  endfunction

  function automatic int lowest(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    logic [3:0] f, act, hreq, lreq;
    int sel; bit shi, tk;
    logic [1:0] n_smp, n_ef, n_tf;
    f = m_flags();
    act = f & m_en[3:0] & {4{m_en[7]}};
    hreq = act & m_pri[3:0];
    lreq = act & ~m_pri[3:0];
    sel = -1; shi = 0;
    if (hreq != 0 && !m_hi) begin sel = lowest(hreq); shi = 1; end
    else if (lreq != 0 && !m_hi && !m_lo) sel = lowest(lreq);
    tk = insn_last && !insn_reti && !cfg_wr && sel >= 0;
    for (int k = 0; k < 2; k++) begin
      n_smp[k] = mc_tick ? ext_n[k] : m_smp[k];
      if (!edge_mode[k]) n_ef[k] = 0;
      else if (mc_tick && m_smp[k] && !ext_n[k]) n_ef[k] = 1;
      else if (tk && sel == 2*k) n_ef[k] = 0;
      else n_ef[k] = m_ef[k];
      if (tmr_ovf[k]) n_tf[k] = 1;
      else if (tk && sel == 2*k+1) n_tf[k] = 0;
      else n_tf[k] = m_tf[k];
    end
    @(posedge clk);
    m_smp = n_smp; m_ef = n_ef; m_tf = n_tf;
    if (cfg_wr) begin if (cfg_sel) m_pri = cfg_wdata; else m_en = cfg_wdata; end
    if (tk) begin
      if (shi) m_hi = 1; else m_lo = 1;
    end else if (insn_last && insn_reti) begin
      if (m_hi) m_hi = 0; else m_lo = 0;
    end
    m_stb = tk;
    if (tk) m_addr = 16'(3 + 8*sel);
    @(negedge clk);
    chk(vec_stb == m_stb, "R10 vec_stb", vec_stb, m_stb);
    if (m_stb) chk(vec_addr == m_addr, "R2 vec_addr", vec_addr, m_addr);
    chk(req_flag == m_flags(), "R7/R8/R9 req_flag", req_flag, m_flags());
    chk({svc_hi, svc_lo} == {m_hi, m_lo}, "R11 svc", {svc_hi, svc_lo}, {m_hi, m_lo});
  endtask

  task automatic quiet();
    mc_tick = 0; tmr_ovf = 0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0;
    insn_last = 0; insn_reti = 0;
  endtask

  task automatic op(input bit l, input bit r, input bit w, input bit s,
                    input logic [7:0] d, input logic [1:0] o);
    insn_last = l; insn_reti = r; cfg_wr = w; cfg_sel = s; cfg_wdata = d; tmr_ovf = o;
    cyc();
    quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    quiet(); ext_n = 2'b11; edge_mode = 2'b00; rst_n = 0;
    m_smp = 2'b11; m_ef = 0; m_tf = 0; m_en = 0; m_pri = 0;
    m_hi = 0; m_lo = 0; m_stb = 0; m_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk(vec_stb == 0, "R1 vec_stb", vec_stb, 0);
    chk({svc_hi, svc_lo} == 0, "R1 svc", {svc_hi, svc_lo}, 0);
    chk(req_flag == 0, "R1 req_flag", req_flag, 0);
    // R1: pending timer but enables zero
    op(0, 0, 0, 0, 0, 2'b01);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_stb == 0, "R1 no vector with enables clear", vec_stb, 0);
    // R3 global bit off
    op(0, 0, 1, 0, 8'h0F, 0);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_stb == 0, "R3 global enable clear", vec_stb, 0);
    op(0, 0, 1, 0, 8'h8F, 0);
    op(1, 0, 0, 0, 0, 2'b10);
    chk(vec_stb == 1 && vec_addr == 16'h000B, "R3 enabled timer0 vector", vec_addr, 16'h000B);
    op(1, 1, 0, 0, 0, 0);
    // R5 polling: timer1 still pending with ext0 level low
    ext_n = 2'b10; mc_tick = 1; op(0, 0, 0, 0, 0, 0);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_addr == 16'h0003 && vec_stb, "R5 ext0 before timer1", vec_addr, 16'h0003);
    ext_n = 2'b11; mc_tick = 1; op(1, 1, 0, 0, 0, 0);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_addr == 16'h001B && vec_stb, "R5 timer1 next", vec_addr, 16'h001B);
    op(1, 1, 0, 0, 0, 0);
    // R4/R6 preemption: timer1 high
    op(0, 0, 1, 1, 8'h08, 0);
    op(0, 0, 0, 0, 0, 2'b01);
    op(1, 0, 0, 0, 0, 0);
    chk(svc_lo && !svc_hi, "R6 low in service", {svc_hi, svc_lo}, 1);
    op(0, 0, 0, 0, 0, 2'b10);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_stb && vec_addr == 16'h001B && svc_hi, "R4 high preempts low", vec_addr, 16'h001B);
    op(0, 0, 0, 0, 0, 2'b01);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_stb == 0, "R6 nothing under high", vec_stb, 0);
    op(1, 1, 0, 0, 0, 0);
    chk(!svc_hi && svc_lo, "R11 release high first", {svc_hi, svc_lo}, 1);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_stb == 0, "R6 low not under low", vec_stb, 0);
    // R10 blocked by reti cycle, then by register write
    op(1, 1, 0, 0, 0, 0);
    chk(vec_stb == 0, "R10 reti blocks", vec_stb, 0);
    op(1, 0, 1, 0, 8'h8F, 0);
    chk(vec_stb == 0, "R10 cfg write blocks", vec_stb, 0);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_stb && vec_addr == 16'h000B, "R12 strobe next cycle", vec_addr, 16'h000B);
    op(1, 1, 0, 0, 0, 0);
    // R10 not remembered: level request drops while blocked
    ext_n = 2'b01; mc_tick = 1; op(0, 0, 0, 0, 0, 0);
    op(1, 1, 0, 0, 0, 0);
    ext_n = 2'b11; mc_tick = 1; op(0, 0, 0, 0, 0, 0);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_stb == 0, "R10 blocked request forgotten", vec_stb, 0);
    // R7 edge capture clears on vector
    edge_mode = 2'b01; ext_n = 2'b10; mc_tick = 1; op(0, 0, 0, 0, 0, 0);
    chk(req_flag[0] == 1, "R7 edge flag set", req_flag[0], 1);
    op(1, 0, 0, 0, 0, 0);
    chk(vec_stb && req_flag[0] == 0, "R7 edge flag cleared", req_flag[0], 0);
    op(1, 1, 0, 0, 0, 0);
    ext_n = 2'b11;
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      mc_tick = (r[1:0] == 0);
      if (r[7:4] == 0) ext_n[0] = ~ext_n[0];
      if (r[11:8] == 0) ext_n[1] = ~ext_n[1];
      if (r[19:12] == 0) edge_mode = r[21:20];
      tmr_ovf = {r[24:22] == 0, r[27:25] == 0};
      insn_last = r[28];
      insn_reti = r[28] && r[29] && r[30];
      cfg_wr = (r[31] && r[3:2] == 2'b11 && r[9] && r[10]);
      cfg_sel = r[13];
      cfg_wdata = {1'b1, 3'b000, r[17:14]};
      cyc();
    end
    quiet();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule